// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits between the byte-load interface of a sector-programmed flash array and its page loader. Every completed byte load, an address and a data byte, is checked against a small set of fixed multi-step command sequences. In the cycle the load arrives, the block sorts it into one of three classes: a command step, a data byte to store, or a write to discard.

The block holds four persistent flags: write protection, identification mode, and one lock for each of the two 8 KB boot regions. One at each end of the address space. These flags are modelled as registers and cleared only by the synchronous reset. While identification mode is on, the block also supplies the identification byte for a read address.

All command sequences share a two-step prefix. The third step picks the command. One branch extends to six steps and then to a final boot-lock selection step. A change of protection waits for the end of the program cycle that follows the sequence. The page loader signals that end with a one-cycle pulse.

Top module: `ucd_top`

## Requirements
- R1: After reset all four flags are 0, the decoder is idle, `erase_ok` is 1 and `id_data` is 00.
- R2: Command steps compare address bits 14..0 and the exact data byte, and ignore address bits 16..15. A load taken as a command step raises only `cmd_hit`, never `byte_ok` or `byte_drop`.
- R3: The prefix AA@5555, 55@2AAA, followed by A0@5555, unlocks writes for the current program cycle and arms protection on. At the next `pgm_done`, `ev_prot_on` pulses in that cycle and `prot_on` reads 1 from the next cycle.
- R4: The sequence AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 unlocks writes and arms protection off. At the next `pgm_done`, `ev_prot_off` pulses and `prot_on` reads 0 from the next cycle.
- R5: The prefix followed by 90@5555 pulses `ev_id_enter` in the load cycle, and `id_mode` is 1 from the next cycle. The prefix followed by F0@5555 pulses `ev_id_exit`, and `id_mode` is 0 from the next cycle.
- R6: The six-step sequence ending in 40@5555 must be followed by one more load. A load of 00 to the full 17-bit address 00000 sets `lock_lo`. A load of FF to 1FFFF sets `lock_hi`.
- R7: A load that does not match the expected next step returns the decoder to idle, and that load is judged as a data byte. The decoder does not re-check it as the start of a new sequence.
- R8: A data byte gives `byte_ok` when protection is off or writes are unlocked for the current cycle. Otherwise it gives `byte_drop`.
- R9: A data byte to addresses 00000..01FFF while `lock_lo` is set, or to 1E000..1FFFF while `lock_hi` is set, gives `byte_drop`. `erase_ok` is 0 whenever either lock is set.
- R10: In identification mode, `id_data` for `rd_addr` 00002 is FE, or FF if the lower region is locked. For 1FFF2 it is FE or FF in the same way for the upper region. For any other address it is 1F when bit 0 is 0 and D5 when bit 0 is 1. Outside identification mode `id_data` is 00.
- R11: `pgm_done` ends the write unlock and applies any pending protection change. A load in the same cycle is judged with the state from before that cycle. If that load is a step that unlocks writes, its unlock and arming survive the `pgm_done`.
- R12: Lock flags are never cleared by any load or by `pgm_done`. Only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A byte load completes this cycle |
| ld_addr | input | 17 | Load address |
| ld_data | input | 8 | Load data |
| pgm_done | input | 1 | End-of-program-cycle pulse from the page loader |
| rd_addr | input | 17 | Read address for the identification readout |
| byte_ok | output | 1 | Load is a data byte to store |
| byte_drop | output | 1 | Load is a data byte to discard |
| cmd_hit | output | 1 | Load is a command step |
| ev_prot_on | output | 1 | Protection is being turned on this cycle |
| ev_prot_off | output | 1 | Protection is being turned off this cycle |
| ev_id_enter | output | 1 | Identification mode is entered |
| ev_id_exit | output | 1 | Identification mode is left |
| prot_on | output | 1 | Write-protection flag |
| id_mode | output | 1 | Identification-mode flag |
| lock_lo | output | 1 | Lower boot region locked |
| lock_hi | output | 1 | Upper boot region locked |
| erase_ok | output | 1 | Full-chip erase permitted |
| id_data | output | 8 | Identification byte for rd_addr |

## Verification
Two functions can fall in the same cycle: the end of a program cycle, and a load that completes a command step or carries data. The bench provokes this collision in directed cases, for example an A0 third step with `pgm_done` asserted in the same cycle. Its random mix of sequences also raises `pgm_done` at random during steps. Each case is judged against a bench model. In that model, the load is classified with the state from before the cycle, the pending protection change is applied, and the step's new unlock is kept for the following cycle.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_K1, ST_K2, ST_X3, ST_X4, ST_X5, ST_BSEL
    } seq_st_t;

    typedef struct packed {
        logic data;
        logic cmd;
        logic arm_on;
        logic arm_off;
        logic id_in;
        logic id_out;
        logic lk_lo;
        logic lk_hi;
    } seq_act_t;

    localparam logic [14:0] ADR_A   = 15'h5555;
    localparam logic [14:0] ADR_B   = 15'h2AAA;
    localparam logic [7:0]  C_K1    = 8'hAA;
    localparam logic [7:0]  C_K2    = 8'h55;
    localparam logic [7:0]  C_ON    = 8'hA0;
    localparam logic [7:0]  C_EXT   = 8'h80;
    localparam logic [7:0]  C_IDIN  = 8'h90;
    localparam logic [7:0]  C_IDOUT = 8'hF0;
    localparam logic [7:0]  C_OFF   = 8'h20;
    localparam logic [7:0]  C_LOCK  = 8'h40;
    localparam logic [7:0]  C_LKLO  = 8'h00;
    localparam logic [7:0]  C_LKHI  = 8'hFF;
    localparam logic [7:0]  MAKER   = 8'h1F;
    localparam logic [7:0]  DEVICE  = 8'hD5;
    localparam logic [7:0]  ID_FREE = 8'hFE;

    function automatic logic step_is(logic [14:0] a, logic [7:0] d,
                                     logic [14:0] ea, logic [7:0] ed);
        return (a == ea) && (d == ed);
    endfunction

endpackage

// File: rtl/ucd_seq_fsm.sv
module ucd_seq_fsm
    import ucd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    output seq_act_t          act
);
    seq_st_t     st, nxt;
    logic [14:0] a15;

    assign a15 = ld_addr[14:0];

    always_comb begin
        act = '0;
        nxt = st;
        if (ld_valid) begin
            act.cmd = 1'b1;
            nxt     = ST_IDLE;
            unique case (st)
                ST_IDLE: if (step_is(a15, ld_data, ADR_A, C_K1)) nxt = ST_K1;
                         else act.cmd = 1'b0;
                ST_K1:   if (step_is(a15, ld_data, ADR_B, C_K2)) nxt = ST_K2;
                         else act.cmd = 1'b0;
                ST_K2:   if (step_is(a15, ld_data, ADR_A, C_ON))    act.arm_on = 1'b1;
                         else if (step_is(a15, ld_data, ADR_A, C_IDIN))  act.id_in  = 1'b1;
                         else if (step_is(a15, ld_data, ADR_A, C_IDOUT)) act.id_out = 1'b1;
                         else if (step_is(a15, ld_data, ADR_A, C_EXT))   nxt = ST_X3;
                         else act.cmd = 1'b0;
                ST_X3:   if (step_is(a15, ld_data, ADR_A, C_K1)) nxt = ST_X4;
                         else act.cmd = 1'b0;
                ST_X4:   if (step_is(a15, ld_data, ADR_B, C_K2)) nxt = ST_X5;
                         else act.cmd = 1'b0;
                ST_X5:   if (step_is(a15, ld_data, ADR_A, C_OFF))       act.arm_off = 1'b1;
                         else if (step_is(a15, ld_data, ADR_A, C_LOCK)) nxt = ST_BSEL;
                         else act.cmd = 1'b0;
                ST_BSEL: if (ld_addr == '0 && ld_data == C_LKLO)      act.lk_lo = 1'b1;
                         else if (ld_addr == '1 && ld_data == C_LKHI) act.lk_hi = 1'b1;
                         else act.cmd = 1'b0;
                default: act.cmd = 1'b0;
            endcase
            act.data = !act.cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

    // R2: the sequence state moves only on a completed load
    p_adv_on_load_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(ld_valid) |-> $stable(st));

    // R7: a data verdict always leaves the decoder idle
    p_abort_idle_r7: assert property (@(posedge clk) disable iff (rst)
        act.data |=> st == ST_IDLE);

endmodule

// File: rtl/ucd_flags.sv
module ucd_flags
    import ucd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_act_t act,
    input  logic     pgm_done,
    output logic     prot_q,
    output logic     unl_q,
    output logic     id_q,
    output logic     lk_lo_q,
    output logic     lk_hi_q,
    output logic     ev_on,
    output logic     ev_off
);
    logic pend_on, pend_off;

    assign ev_on  = pgm_done && pend_on;
    assign ev_off = pgm_done && pend_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q   <= 1'b0;
            unl_q    <= 1'b0;
            id_q     <= 1'b0;
            lk_lo_q  <= 1'b0;
            lk_hi_q  <= 1'b0;
            pend_on  <= 1'b0;
            pend_off <= 1'b0;
        end else begin
            if (pgm_done) begin
                unl_q    <= 1'b0;
                pend_on  <= 1'b0;
                pend_off <= 1'b0;
                if (pend_on)       prot_q <= 1'b1;
                else if (pend_off) prot_q <= 1'b0;
            end
            if (act.arm_on) begin
                unl_q    <= 1'b1;
                pend_on  <= 1'b1;
                pend_off <= 1'b0;
            end
            if (act.arm_off) begin
                unl_q    <= 1'b1;
                pend_off <= 1'b1;
                pend_on  <= 1'b0;
            end
            if (act.id_in)  id_q    <= 1'b1;
            if (act.id_out) id_q    <= 1'b0;
            if (act.lk_lo)  lk_lo_q <= 1'b1;
            if (act.lk_hi)  lk_hi_q <= 1'b1;
        end
    end

    // R3: protection changes only right after a program-cycle end
    p_prot_at_done_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(prot_q) |-> $past(pgm_done));

    // R12: lock flags never fall outside reset
    p_lock_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        !$fell(lk_lo_q) && !$fell(lk_hi_q));

    // R5: entering identification mode is visible the next cycle
    p_id_enter_r5: assert property (@(posedge clk) disable iff (rst)
        act.id_in |=> id_q);

    // R11: an unlock armed with a coincident pgm_done survives it
    p_unlock_keep_r11: assert property (@(posedge clk) disable iff (rst)
        (act.arm_on || act.arm_off) |=> unl_q);

endmodule

// File: rtl/ucd_id_read.sv
module ucd_id_read
    import ucd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              id_q,
    input  logic              lk_lo_q,
    input  logic              lk_hi_q,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        id_data
);
    localparam logic [ADDR_W-1:0] LO_STAT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] HI_STAT = ~ADDR_W'(13);

    always_comb begin
        if (!id_q)                   id_data = 8'h00;
        else if (rd_addr == LO_STAT) id_data = ID_FREE | {7'd0, lk_lo_q};
        else if (rd_addr == HI_STAT) id_data = ID_FREE | {7'd0, lk_hi_q};
        else if (rd_addr[0])         id_data = DEVICE;
        else                         id_data = MAKER;
    end
endmodule

// File: rtl/ucd_top.sv
module ucd_top
    import ucd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BOOT_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    input  logic              pgm_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              byte_ok,
    output logic              byte_drop,
    output logic              cmd_hit,
    output logic              ev_prot_on,
    output logic              ev_prot_off,
    output logic              ev_id_enter,
    output logic              ev_id_exit,
    output logic              prot_on,
    output logic              id_mode,
    output logic              lock_lo,
    output logic              lock_hi,
    output logic              erase_ok,
    output logic [7:0]        id_data
);
    localparam int REG_W = ADDR_W - BOOT_W;

    seq_act_t   act;
    logic       unl;
    logic       in_lo, in_hi, blocked, allowed;
    logic [REG_W-1:0] region;

    ucd_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst(rst), .ld_valid(ld_valid),
        .ld_addr(ld_addr), .ld_data(ld_data), .act(act));

    ucd_flags u_flags (
        .clk(clk), .rst(rst), .act(act), .pgm_done(pgm_done),
        .prot_q(prot_on), .unl_q(unl), .id_q(id_mode),
        .lk_lo_q(lock_lo), .lk_hi_q(lock_hi),
        .ev_on(ev_prot_on), .ev_off(ev_prot_off));

    ucd_id_read #(.ADDR_W(ADDR_W)) u_id (
        .id_q(id_mode), .lk_lo_q(lock_lo), .lk_hi_q(lock_hi),
        .rd_addr(rd_addr), .id_data(id_data));

    assign region  = ld_addr[ADDR_W-1:BOOT_W];
    assign in_lo   = (region == '0);
    assign in_hi   = (region == '1);
    assign blocked = (in_lo && lock_lo) || (in_hi && lock_hi);
    assign allowed = !prot_on || unl;

    assign byte_ok     = act.data && allowed && !blocked;
    assign byte_drop   = act.data && !byte_ok;
    assign cmd_hit     = act.cmd;
    assign ev_id_enter = act.id_in;
    assign ev_id_exit  = act.id_out;
    assign erase_ok    = !(lock_lo || lock_hi);

    // R2: a load gets at most one verdict
    p_one_verdict_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({byte_ok, byte_drop, cmd_hit}));

    // R8: with protection on and no unlock, nothing is stored
    p_guard_r8: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && prot_on && !unl) |-> !byte_ok);

    // R9: a locked lower region never accepts a byte
    p_boot_lo_r9: assert property (@(posedge clk) disable iff (rst)
        (byte_ok && lock_lo) |-> (region != '0));

endmodule

// File: tb/test_ucd_top.sv
module test_ucd_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_valid, pgm_done;
    logic [16:0] ld_addr, rd_addr;
    logic [7:0]  ld_data;
    logic        byte_ok, byte_drop, cmd_hit, ev_prot_on, ev_prot_off;
    logic        ev_id_enter, ev_id_exit, prot_on, id_mode, lock_lo, lock_hi, erase_ok;
    logic [7:0]  id_data;

    int n_run = 0, n_fail = 0;

    // model state
    int mst;
    bit mprot, munl, mpon, mpoff, midm, mllo, mlhi;

    always #2.5 clk = ~clk;

    ucd_top i_ucd_top (.*);

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] id_exp(input logic [16:0] ra);
        if (!midm) return 8'h00;
        if (ra == 17'h00002) return 8'hFE | {7'd0, mllo};
        if (ra == 17'h1FFF2) return 8'hFE | {7'd0, mlhi};
        return ra[0] ? 8'hD5 : 8'h1F;
    endfunction

    task automatic step(input bit v, input logic [16:0] a, input logic [7:0] d,
                        input bit done, input logic [16:0] ra);
        bit dat = 0, cmd = 0, on = 0, off = 0, iin = 0, iout = 0, llo = 0, lhi = 0;
        bit ok, blk;
        int nst = mst;
        logic [14:0] a15 = a[14:0];
        @(negedge clk);
        ld_valid = v; ld_addr = a; ld_data = d; pgm_done = done; rd_addr = ra;
        #1;
        if (v) begin
            cmd = 1; nst = 0;
            case (mst)
                0: if (a15 == 15'h5555 && d == 8'hAA) nst = 1; else cmd = 0;
                1: if (a15 == 15'h2AAA && d == 8'h55) nst = 2; else cmd = 0;
                2: if (a15 == 15'h5555 && d == 8'hA0) on = 1;
                   else if (a15 == 15'h5555 && d == 8'h90) iin = 1;
                   else if (a15 == 15'h5555 && d == 8'hF0) iout = 1;
                   else if (a15 == 15'h5555 && d == 8'h80) nst = 3;
                   else cmd = 0;
                3: if (a15 == 15'h5555 && d == 8'hAA) nst = 4; else cmd = 0;
                4: if (a15 == 15'h2AAA && d == 8'h55) nst = 5; else cmd = 0;
                5: if (a15 == 15'h5555 && d == 8'h20) off = 1;
                   else if (a15 == 15'h5555 && d == 8'h40) nst = 6;
                   else cmd = 0;
                default: if (a == 17'h0 && d == 8'h00) llo = 1;
                   else if (a == 17'h1FFFF && d == 8'hFF) lhi = 1;
                   else cmd = 0;
            endcase
            dat = !cmd;
        end
        blk = (a[16:13] == 4'h0 && mllo) || (a[16:13] == 4'hF && mlhi);
        ok  = dat && (!mprot || munl) && !blk;
        chk("R2 cmd_hit", cmd_hit, cmd);
        chk("R8 byte_ok", byte_ok, ok);
        chk("R8 byte_drop", byte_drop, dat && !ok);
        chk("R3 ev_prot_on", ev_prot_on, done && mpon);
        chk("R4 ev_prot_off", ev_prot_off, done && mpoff);
        chk("R5 ev_id_enter", ev_id_enter, iin);
        chk("R5 ev_id_exit", ev_id_exit, iout);
        chk("R3 prot_on", prot_on, mprot);
        chk("R5 id_mode", id_mode, midm);
        chk("R6 lock_lo", lock_lo, mllo);
        chk("R6 lock_hi", lock_hi, mlhi);
        chk("R9 erase_ok", erase_ok, !(mllo || mlhi));
        chk("R10 id_data", id_data, id_exp(ra));
        // model update
        mst = nst;
        if (done) begin
            munl = 0;
            if (mpon) mprot = 1; else if (mpoff) mprot = 0;
            mpon = 0; mpoff = 0;
        end
        if (on)   begin munl = 1; mpon = 1; mpoff = 0; end
        if (off)  begin munl = 1; mpoff = 1; mpon = 0; end
        if (iin)  midm = 1;
        if (iout) midm = 0;
        if (llo)  mllo = 1;
        if (lhi)  mlhi = 1;
    endtask

    function automatic logic [16:0] ra_pick();
        case ($urandom % 4)
            0: return 17'h00002;
            1: return 17'h1FFF2;
            default: return 17'($urandom);
        endcase
    endfunction

    task automatic ld(input logic [16:0] a, input logic [7:0] d, input bit done = 0);
        step(1, a, d, done, ra_pick());
    endtask

    // kind: 0 enable, 1 id enter, 2 id exit, 3 disable, 4 lock lower, 5 lock upper
    task automatic do_seq(input int kind, input bit corrupt, input bit rnd_done);
        logic [16:0] sa[7];
        logic [7:0]  sd[7];
        int n = 3, bad;
        logic [1:0] hi = 2'($urandom);
        sa[0] = {hi, 15'h5555}; sd[0] = 8'hAA;
        sa[1] = {hi, 15'h2AAA}; sd[1] = 8'h55;
        sa[2] = {hi, 15'h5555};
        case (kind)
            0: sd[2] = 8'hA0;
            1: sd[2] = 8'h90;
            2: sd[2] = 8'hF0;
            default: begin
                sd[2] = 8'h80;
                sa[3] = sa[0]; sd[3] = 8'hAA;
                sa[4] = sa[1]; sd[4] = 8'h55;
                sa[5] = sa[0]; sd[5] = (kind == 3) ? 8'h20 : 8'h40;
                n = 6;
                if (kind == 4) begin sa[6] = 17'h00000; sd[6] = 8'h00; n = 7; end
                if (kind == 5) begin sa[6] = 17'h1FFFF; sd[6] = 8'hFF; n = 7; end
            end
        endcase
        bad = corrupt ? int'($urandom % n) : -1;
        for (int i = 0; i < n; i++)
            ld(sa[i], (i == bad) ? (sd[i] ^ 8'h01) : sd[i], rnd_done && ($urandom % 8 == 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired got=0 exp=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1; ld_valid = 0; ld_addr = '0; ld_data = '0; pgm_done = 0; rd_addr = '0;
        mst = 0; {mprot, munl, mpon, mpoff, midm, mllo, mlhi} = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        chk("R1 prot_on", prot_on, 0);
        chk("R1 erase_ok", erase_ok, 1);
        chk("R1 id_data", id_data, 8'h00);
        step(0, '0, '0, 0, 17'h00002);
        // R7: abort after first step, the load is stored as data
        ld(17'h05555, 8'hAA);
        ld(17'h00100, 8'h12);
        chk("R7 abort data", byte_ok, 1);
        // R2: bits 16..15 ignored for command compare
        ld(17'h1D555, 8'hAA);
        chk("R2 high bits", cmd_hit, 1);
        ld(17'h0AAAA, 8'h55);
        // R3: enable, then data under unlock, then end of cycle
        ld(17'h05555, 8'hA0);
        ld(17'h04000, 8'h77);
        chk("R3 unlocked store", byte_ok, 1);
        step(0, '0, '0, 1, '0);
        chk("R3 ev_prot_on", ev_prot_on, 1);
        step(0, '0, '0, 0, '0);
        chk("R3 prot now on", prot_on, 1);
        // R8: protected write without prefix is discarded
        ld(17'h04000, 8'h33);
        chk("R8 protected drop", byte_drop, 1);
        // R11: A0 step coincident with pgm_done keeps the new unlock
        do_seq(0, 0, 0);
        ld(17'h04001, 8'h44);
        step(0, '0, '0, 1, '0);
        ld(17'h05555, 8'hAA); ld(17'h02AAA, 8'h55);
        ld(17'h05555, 8'hA0, 1);
        ld(17'h04002, 8'h45);
        chk("R11 unlock survives", byte_ok, 1);
        step(0, '0, '0, 1, '0);
        // R4: disable
        do_seq(3, 0, 0);
        ld(17'h04003, 8'h46);
        step(0, '0, '0, 1, '0);
        chk("R4 ev_prot_off", ev_prot_off, 1);
        // R6 + R9: lock lower, then write into it
        do_seq(4, 0, 0);
        ld(17'h00100, 8'h99);
        chk("R9 locked lower drop", byte_drop, 1);
        chk("R9 erase_ok", erase_ok, 0);
        // R5 + R10: identification mode readout
        do_seq(1, 0, 0);
        step(0, '0, '0, 0, 17'h00002);
        chk("R10 lower status", id_data, 8'hFF);
        step(0, '0, '0, 0, 17'h1FFF2);
        chk("R10 upper status", id_data, 8'hFE);
        step(0, '0, '0, 0, 17'h00001);
        chk("R10 device code", id_data, 8'hD5);
        do_seq(2, 0, 0);
        // R12: lock survives disable sequence and cycle end
        do_seq(3, 0, 0);
        step(0, '0, '0, 1, '0);
        step(0, '0, '0, 0, '0);
        chk("R12 lock kept", lock_lo, 1);
        // random mix
        for (int it = 0; it < 2500; it++) begin
            int r = int'($urandom % 12);
            if (r < 4)       ld(17'($urandom), 8'($urandom), $urandom % 10 == 0);
            else if (r == 4) step(0, '0, '0, 0, ra_pick());
            else if (r == 5) step(0, '0, '0, 1, ra_pick());
            else begin
                int k = int'($urandom % 6);
                if (k >= 4 && ($urandom % 4 != 0)) k = int'($urandom % 4);
                do_seq(k, $urandom % 4 == 0, 1);
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule